// File: doc/BRIEF.md
# Chunked Serial Flash Read Sequencer

This block copies a contiguous region of a serial NOR flash into on-chip memory without processor help. A single-cycle start pulse supplies the flash start address, the destination base address and the byte count. The engine breaks the request into transactions of bounded size. Each transaction opens chip select and sends the plain read command with a three-byte address. The bytes clocked back during those four header bytes are dropped. Every following byte goes out on a valid/ready write port, at an address that increases by one for each byte.

Between two transactions chip select stays high for a programmable number of clock cycles, which covers the flash's minimum deselect time. While the write port holds ready low, the engine pauses the serial clock between bytes, so no received byte ever has to be buffered beyond one output register. A one-cycle done pulse marks the end of the whole request, after the last byte has been taken by the write port.

Top module: `flash_chunk_reader`

## Requirements
- R1: Each transaction sends the byte 0x03 first and then the 24-bit flash address, most significant byte first. Bits are shifted most significant bit first. SCK idles low, MOSI changes only while SCK is low, and MISO is sampled on the rising SCK edge.
- R2: A transaction carries at most MAX_CHUNK payload bytes. It clocks exactly 4 plus its payload length bytes while chip select is low.
- R3: The four bytes received during the header of each transaction are never written out. Payload byte k of the request is written with wr_data equal to the flash byte at address src_addr+k and with wr_addr equal to dst_addr+k, in increasing k.
- R4: Transaction n starts at flash address src_addr + n*MAX_CHUNK. The final transaction carries the remainder of the length when the length is not a multiple of MAX_CHUNK.
- R5: Between two transactions of one request, spi_cs_n stays high for at least GAP_CYCLES clock cycles. spi_sck is low whenever spi_cs_n is high.
- R6: A start with length 0 raises done in the following cycle and leaves spi_cs_n high and spi_sck low.
- R7: While wr_valid is high and wr_ready is low, wr_valid, wr_data and wr_addr hold their values, and no payload byte is lost however long ready stays low.
- R8: A start pulse that arrives while busy is high is ignored. The running request completes unchanged and no further transaction follows it.
- R9: done is a single-cycle pulse, raised once per request after the last payload byte has been accepted. busy is high from the cycle after an accepted nonzero start until done.
- R10: After reset, spi_cs_n is 1, and spi_sck, wr_valid, busy and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Single-cycle request pulse |
| src_addr | input | 24 | Flash start address |
| dst_addr | input | DST_W | Destination base address |
| length | input | LEN_W | Number of payload bytes to copy |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| wr_valid | output | 1 | Write port data valid |
| wr_ready | input | 1 | Write port accepts data |
| wr_addr | output | DST_W | Write port byte address |
| wr_data | output | 8 | Write port byte |

## Verification
The bench builds the block with MAX_CHUNK = 8, GAP_CYCLES = 6 and SCK_HALF = 1, and keeps DST_W = 16 and LEN_W = 12. The small chunk size makes requests of a few dozen bytes split into several transactions. This brings multi-chunk address stepping, an exact-multiple length and a short remainder chunk within a short run. The short gap and the fast serial clock keep each run brief, while gap enforcement and clock stalling under random and long back-pressure can still be observed at the pins.

// File: rtl/flash_rd_pkg.sv
// Shared constants and the sequencer state type for the chunked flash reader.
// Assumes a flash that accepts the plain 0x03 read with a 3-byte address.
package flash_rd_pkg;
    localparam int          HDR_BYTES = 4;      // command byte plus three address bytes
    localparam int          FADDR_W   = 24;     // flash address width
    localparam logic [7:0]  RD_CMD    = 8'h03;  // plain read opcode

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_XFER,
        ST_CLOSE,
        ST_GAP,
        ST_FINISH
    } seq_state_t;
endpackage

// File: rtl/flash_rd_planner.sv
// Chunk planner: holds the running flash address, destination base and
// remaining length of a request, and offers the size of the next chunk.
// Assumes LEN_W is wider than the chunk-size field.
module flash_rd_planner
    import flash_rd_pkg::*;
#(
    parameter int DST_W     = 32,
    parameter int LEN_W     = 24,
    parameter int MAX_CHUNK = 60,
    parameter int CHUNK_W   = $clog2(MAX_CHUNK + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FADDR_W-1:0] src_in,
    input  logic [DST_W-1:0]   dst_in,
    input  logic [LEN_W-1:0]   len_in,
    input  logic               advance,
    output logic [FADDR_W-1:0] flash_addr,
    output logic [DST_W-1:0]   dst_base,
    output logic [CHUNK_W-1:0] chunk_len,
    output logic               last_chunk
);
    logic [LEN_W-1:0] remain;

    // Next chunk size: the remainder when it fits, otherwise the cap.
    always_comb begin
        last_chunk = (remain <= LEN_W'(MAX_CHUNK));
        chunk_len  = last_chunk ? remain[CHUNK_W-1:0] : CHUNK_W'(MAX_CHUNK);
    end

    // Latch a new request, or step all three counters past a finished chunk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain     <= '0;
            flash_addr <= '0;
            dst_base   <= '0;
        end else if (load) begin
            remain     <= len_in;
            flash_addr <= src_in;
            dst_base   <= dst_in;
        end else if (advance) begin
            remain     <= remain - LEN_W'(chunk_len);
            flash_addr <= flash_addr + FADDR_W'(chunk_len);
            dst_base   <= dst_base + DST_W'(chunk_len);
        end
    end
endmodule

// File: rtl/flash_rd_shifter.sv
// Mode-0 byte shifter: on go it clocks one byte out on MOSI and in from
// MISO, MSB first, with SCK_HALF system cycles per SCK phase. SCK stays low
// whenever no byte is in flight, so withholding go stalls the serial clock.
module flash_rd_shifter #(
    parameter int SCK_HALF = 2,
    parameter int DIV_W    = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       active,
    output logic       fin,
    output logic [7:0] rx_byte
);
    logic [7:0]       tx_sr;
    logic [7:0]       rx_sr;
    logic [2:0]       bit_cnt;
    logic [DIV_W-1:0] div_cnt;

    assign mosi    = tx_sr[7];
    assign rx_byte = rx_sr;

    // Phase sequencer: rise samples MISO, fall advances MOSI or ends the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            bit_cnt <= '0;
            div_cnt <= '0;
            sck     <= 1'b0;
            active  <= 1'b0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go && !active) begin
                tx_sr   <= tx_byte;
                bit_cnt <= '0;
                div_cnt <= '0;
                active  <= 1'b1;
            end else if (active) begin
                if (div_cnt == DIV_W'(SCK_HALF - 1)) begin
                    div_cnt <= '0;
                    if (!sck) begin
                        sck   <= 1'b1;
                        rx_sr <= {rx_sr[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bit_cnt == 3'd7) begin
                            active <= 1'b0;
                            fin    <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 3'd1;
                            tx_sr   <= {tx_sr[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + DIV_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/flash_rd_gap_timer.sv
// Deselect timer: a load pulse starts a countdown of GAP_CYCLES; expired is
// high once the count has run out. Assumes GAP_CYCLES >= 1.
module flash_rd_gap_timer #(
    parameter int GAP_CYCLES = 50,
    parameter int CNT_W      = $clog2(GAP_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    logic [CNT_W-1:0] count;

    assign expired = (count == '0);

    // Reload on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= CNT_W'(GAP_CYCLES);
        end else if (count != '0) begin
            count <= count - CNT_W'(1);
        end
    end
endmodule

// File: rtl/flash_chunk_reader.sv
// Chunked serial flash read sequencer. Copies length bytes from flash
// address src_addr to dst_addr. Each chunk of at most MAX_CHUNK bytes is one
// chip-select transaction: 0x03, three address bytes, then payload. Header
// receive bytes are dropped, payload goes out on a one-deep valid/ready
// register. A payload byte is launched only when that register is empty, so
// back-pressure stalls SCK instead of overrunning. Assumes wr_ready may drop
// at any time and that the flash needs no dummy cycles.
module flash_chunk_reader
    import flash_rd_pkg::*;
#(
    parameter int DST_W      = 32,
    parameter int LEN_W      = 24,
    parameter int MAX_CHUNK  = 60,
    parameter int GAP_CYCLES = 50,
    parameter int SCK_HALF   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FADDR_W-1:0] src_addr,
    input  logic [DST_W-1:0]   dst_addr,
    input  logic [LEN_W-1:0]   length,
    output logic               busy,
    output logic               done,
    output logic               spi_cs_n,
    output logic               spi_sck,
    output logic               spi_mosi,
    input  logic               spi_miso,
    output logic               wr_valid,
    input  logic               wr_ready,
    output logic [DST_W-1:0]   wr_addr,
    output logic [7:0]         wr_data
);
    localparam int CHUNK_W = $clog2(MAX_CHUNK + 1);
    localparam int IDX_W   = $clog2(MAX_CHUNK + HDR_BYTES + 1);

    seq_state_t         state;
    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   total;
    logic               inflight;
    logic               launch;
    logic [7:0]         tx_byte;
    logic               out_valid;
    logic [7:0]         out_data;
    logic [DST_W-1:0]   out_addr;
    logic               done_q;
    logic               cs_q;

    logic [FADDR_W-1:0] flash_addr;
    logic [DST_W-1:0]   dst_base;
    logic [CHUNK_W-1:0] chunk_len;
    logic               last_chunk;
    logic               sh_active;
    logic               sh_fin;
    logic [7:0]         sh_rx;
    logic               gap_expired;
    logic               plan_load;
    logic               plan_advance;
    logic               gap_load;

    flash_rd_planner #(
        .DST_W     (DST_W),
        .LEN_W     (LEN_W),
        .MAX_CHUNK (MAX_CHUNK)
    ) u_plan (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (plan_load),
        .src_in     (src_addr),
        .dst_in     (dst_addr),
        .len_in     (length),
        .advance    (plan_advance),
        .flash_addr (flash_addr),
        .dst_base   (dst_base),
        .chunk_len  (chunk_len),
        .last_chunk (last_chunk)
    );

    flash_rd_shifter #(
        .SCK_HALF (SCK_HALF)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (launch),
        .tx_byte (tx_byte),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .active  (sh_active),
        .fin     (sh_fin),
        .rx_byte (sh_rx)
    );

    flash_rd_gap_timer #(
        .GAP_CYCLES (GAP_CYCLES)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .expired (gap_expired)
    );

    // Control strobes for the planner and the gap timer.
    always_comb begin
        plan_load    = (state == ST_IDLE) && start && (length != '0);
        plan_advance = (state == ST_CLOSE);
        gap_load     = (state == ST_CLOSE) && !last_chunk;
    end

    // Bytes clocked in this chunk, and the launch rule that stalls SCK.
    always_comb begin
        total  = IDX_W'(chunk_len) + IDX_W'(HDR_BYTES);
        launch = (state == ST_XFER) && !inflight && !sh_active &&
                 ((idx < IDX_W'(HDR_BYTES)) || !out_valid);
    end

    // Header framing: opcode, then the address high byte first, then filler.
    always_comb begin
        case (idx)
            IDX_W'(0): tx_byte = RD_CMD;
            IDX_W'(1): tx_byte = flash_addr[23:16];
            IDX_W'(2): tx_byte = flash_addr[15:8];
            IDX_W'(3): tx_byte = flash_addr[7:0];
            default:   tx_byte = 8'h00;
        endcase
    end

    // Request sequencer: chunk open, byte exchange, close, gap and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            inflight  <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_addr  <= '0;
            done_q    <= 1'b0;
            cs_q      <= 1'b1;
        end else begin
            done_q <= 1'b0;
            if (out_valid && wr_ready) begin
                out_valid <= 1'b0;
            end
            if (launch) begin
                inflight <= 1'b1;
            end
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (length == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state <= ST_OPEN;
                        end
                    end
                end
                ST_OPEN: begin
                    cs_q  <= 1'b0;
                    idx   <= '0;
                    state <= ST_XFER;
                end
                ST_XFER: begin
                    if (sh_fin) begin
                        inflight <= 1'b0;
                        idx      <= idx + IDX_W'(1);
                        if (idx >= IDX_W'(HDR_BYTES)) begin
                            out_valid <= 1'b1;
                            out_data  <= sh_rx;
                            out_addr  <= dst_base + DST_W'(idx - IDX_W'(HDR_BYTES));
                        end
                        if (idx == total - IDX_W'(1)) begin
                            state <= ST_CLOSE;
                        end
                    end
                end
                ST_CLOSE: begin
                    cs_q  <= 1'b1;
                    state <= last_chunk ? ST_FINISH : ST_GAP;
                end
                ST_GAP: begin
                    if (gap_expired) begin
                        state <= ST_OPEN;
                    end
                end
                ST_FINISH: begin
                    if (!out_valid) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign spi_cs_n = cs_q;
    assign wr_valid = out_valid;
    assign wr_addr  = out_addr;
    assign wr_data  = out_data;
endmodule

// File: rtl/flash_chunk_reader_chk.sv
// Protocol checker for the chunked flash reader, bound to every instance.
// Watches only the ports; counts deselect cycles itself so the gap window
// does not depend on a parameterised delay.
module flash_chunk_reader_chk #(
    parameter int DST_W      = 32,
    parameter int LEN_W      = 24,
    parameter int GAP_CYCLES = 50
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] length,
    input logic             busy,
    input logic             done,
    input logic             spi_cs_n,
    input logic             spi_sck,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic [DST_W-1:0] wr_addr,
    input logic [7:0]       wr_data
);
    logic [15:0] hi_cnt;
    logic        seen_low;

    // Count chip-select-high cycles inside a request, after its first chunk.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            hi_cnt   <= '0;
            seen_low <= 1'b0;
        end else if (!spi_cs_n) begin
            hi_cnt   <= '0;
            seen_low <= 1'b1;
        end else if (hi_cnt != 16'hFFFF) begin
            hi_cnt <= hi_cnt + 16'd1;
        end
    end

    p_sck_low_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    p_min_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(spi_cs_n) && seen_low) |-> (hi_cnt >= 16'(GAP_CYCLES)));

    p_zero_len_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (length == '0)) |=> (done && spi_cs_n));

    p_hold_stalled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && spi_cs_n && !wr_valid));

    p_busy_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (length != '0)) |=> busy);
endmodule

bind flash_chunk_reader flash_chunk_reader_chk #(
    .DST_W      (DST_W),
    .LEN_W      (LEN_W),
    .GAP_CYCLES (GAP_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .length   (length),
    .busy     (busy),
    .done     (done),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
);

// File: tb/flash_chunk_reader_test.sv
// Directed bench: a behavioural mode-0 flash, a write-port sink with
// selectable back-pressure, and one task per scenario.
module flash_chunk_reader_test;
    localparam int DST_W = 16;
    localparam int LEN_W = 12;
    localparam int MAXC  = 8;
    localparam int GAP   = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [23:0]      src_addr = '0;
    logic [DST_W-1:0] dst_addr = '0;
    logic [LEN_W-1:0] length = '0;
    logic             busy, done, spi_cs_n, spi_sck, spi_mosi;
    logic             spi_miso = 1'b1;
    logic             wr_valid;
    logic             wr_ready = 1'b1;
    logic [DST_W-1:0] wr_addr;
    logic [7:0]       wr_data;

    int total_checks = 0;
    int fail_checks  = 0;

    always #10 clk = ~clk;   // 20 ns period, 50 MHz

    flash_chunk_reader #(
        .DST_W (DST_W), .LEN_W (LEN_W), .MAX_CHUNK (MAXC),
        .GAP_CYCLES (GAP), .SCK_HALF (1)
    ) uut (
        .clk (clk), .rst_n (rst_n), .start (start), .src_addr (src_addr),
        .dst_addr (dst_addr), .length (length), .busy (busy), .done (done),
        .spi_cs_n (spi_cs_n), .spi_sck (spi_sck), .spi_mosi (spi_mosi),
        .spi_miso (spi_miso), .wr_valid (wr_valid), .wr_ready (wr_ready),
        .wr_addr (wr_addr), .wr_data (wr_data)
    );

    function automatic logic [7:0] fdata(input logic [23:0] a);
        return (a[7:0] ^ 8'h5C) + a[15:8] + {a[19:16], a[23:20]};
    endfunction

    // ---------------- flash model ----------------
    logic [7:0]  m_cmd;
    logic [23:0] m_adr;
    int          m_bits = 0;
    int          chunk_n = 0;
    logic [7:0]  ch_cmd [64];
    logic [23:0] ch_adr [64];
    int          ch_bytes [64];

    // Capture command/address on rising SCK; log the transaction on deselect.
    always @(posedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            if (m_bits != 0 && chunk_n < 64) begin
                ch_cmd[chunk_n]   = m_cmd;
                ch_adr[chunk_n]   = m_adr;
                ch_bytes[chunk_n] = m_bits / 8;
                chunk_n           = chunk_n + 1;
            end
            m_bits = 0;
        end else begin
            if (m_bits < 8)       m_cmd = {m_cmd[6:0], spi_mosi};
            else if (m_bits < 32) m_adr = {m_adr[22:0], spi_mosi};
            m_bits = m_bits + 1;
        end
    end

    // Drive MISO on falling SCK: ones during the header, then memory data.
    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            if (m_bits < 32) begin
                spi_miso = 1'b1;
            end else begin
                automatic logic [7:0] b = fdata(m_adr + 24'((m_bits - 32) / 8));
                spi_miso = b[7 - ((m_bits - 32) % 8)];
            end
        end
    end

    // ---------------- write sink and pin monitor ----------------
    logic        clr_req = 1'b0;
    int          bp_mode = 0;
    logic [23:0] exp_src = '0;
    logic [DST_W-1:0] exp_dst = '0;
    int  wr_cnt, addr_err, data_err, hold_err, sck_err, done_cnt, done_wide;
    int  gap_run, min_gap, cyc;
    bit  gap_seen, prev_v, prev_r, prev_done;
    logic [7:0]       prev_d;
    logic [DST_W-1:0] prev_a;
    logic [7:0]       lfsr = 8'hA7;

    always @(negedge clk) begin
        cyc = cyc + 1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (clr_req) begin
            wr_cnt = 0; addr_err = 0; data_err = 0; hold_err = 0; sck_err = 0;
            done_cnt = 0; done_wide = 0; gap_run = 0; min_gap = 1000000;
            gap_seen = 0; prev_v = 0; prev_r = 1; prev_done = 0;
        end else begin
            case (bp_mode)
                1:       wr_ready = lfsr[0] & lfsr[2];
                2:       wr_ready = ((cyc % 60) >= 45);
                default: wr_ready = 1'b1;
            endcase
            if (prev_v && !prev_r &&
                (!wr_valid || wr_data != prev_d || wr_addr != prev_a))
                hold_err = hold_err + 1;
            if (wr_valid && wr_ready) begin
                if (wr_addr != exp_dst + DST_W'(wr_cnt)) addr_err = addr_err + 1;
                if (wr_data != fdata(exp_src + 24'(wr_cnt))) data_err = data_err + 1;
                wr_cnt = wr_cnt + 1;
            end
            prev_v = wr_valid; prev_r = wr_ready; prev_d = wr_data; prev_a = wr_addr;
            if (spi_cs_n && spi_sck) sck_err = sck_err + 1;
            if (!spi_cs_n) begin
                if (gap_seen && gap_run > 0 && gap_run < min_gap) min_gap = gap_run;
                gap_run = 0;
                gap_seen = 1;
            end else if (gap_seen && busy) begin
                gap_run = gap_run + 1;
            end
            if (done) done_cnt = done_cnt + 1;
            if (done && prev_done) done_wide = done_wide + 1;
            prev_done = done;
        end
    end

    // ---------------- helpers ----------------
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total_checks = total_checks + 1;
        if (!ok) begin
            fail_checks = fail_checks + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        clr_req = 1'b1;
        tick();
        tick();
        clr_req = 1'b0;
    endtask

    task automatic pulse_start(input logic [23:0] s, input logic [DST_W-1:0] d,
                               input int n);
        start = 1'b1; src_addr = s; dst_addr = d; length = LEN_W'(n);
        tick();
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (done_cnt == 0 && t < 30000) begin
            tick();
            t++;
        end
        chk(done_cnt != 0, req, t, 0);
        repeat (4) tick();
    endtask

    task automatic check_chunks(input int base, input logic [23:0] s, input int n);
        int expn = (n + MAXC - 1) / MAXC;
        int bad_cmd = 0, bad_adr = 0, bad_len = 0;
        chk(chunk_n - base == expn, "R2 chunk count", chunk_n - base, expn);
        for (int i = 0; i < expn && base + i < 64; i++) begin
            int pl = (n - i * MAXC > MAXC) ? MAXC : n - i * MAXC;
            if (ch_cmd[base + i] != 8'h03) bad_cmd++;
            if (ch_adr[base + i] != s + 24'(i * MAXC)) bad_adr++;
            if (ch_bytes[base + i] != 4 + pl) bad_len++;
        end
        chk(bad_cmd == 0, "R1 opcode/address framing", bad_cmd, 0);
        chk(bad_adr == 0, "R4 chunk address step", bad_adr, 0);
        chk(bad_len == 0, "R2 R4 bytes per chunk", bad_len, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(spi_cs_n && !spi_sck && !wr_valid && !busy && !done,
            "R10 reset outputs", {spi_cs_n, spi_sck, wr_valid, busy, done}, 5'b10000);
    endtask

    task automatic t_zero_len();
        int base = chunk_n;
        clear_stats();
        pulse_start(24'h000100, 16'h0040, 0);
        chk(done == 1'b1, "R6 done next cycle", done, 1);
        chk(spi_cs_n && !busy, "R6 bus untouched", {spi_cs_n, busy}, 2'b10);
        repeat (10) tick();
        chk(chunk_n == base && sck_err == 0 && done_cnt == 1,
            "R6 no transaction", chunk_n - base, 0);
    endtask

    task automatic t_copy(input logic [23:0] s, input logic [DST_W-1:0] d,
                          input int n, input int mode, input string tag);
        int base = chunk_n;
        clear_stats();
        bp_mode = mode; exp_src = s; exp_dst = d;
        pulse_start(s, d, n);
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
        wait_done({"R9 completion ", tag});
        chk(wr_cnt == n, {"R3 payload count ", tag}, wr_cnt, n);
        chk(addr_err == 0 && data_err == 0, {"R3 payload order/data ", tag},
            addr_err + data_err, 0);
        check_chunks(base, s, n);
        if (n > MAXC) chk(min_gap >= GAP, {"R5 deselect gap ", tag}, min_gap, GAP);
        chk(sck_err == 0, {"R5 sck idle while deselected ", tag}, sck_err, 0);
        chk(done_cnt == 1 && done_wide == 0, {"R9 single done ", tag}, done_cnt, 1);
        if (mode != 0) chk(hold_err == 0, {"R7 stalled byte held ", tag}, hold_err, 0);
        bp_mode = 0;
    endtask

    task automatic t_start_busy();
        int base = chunk_n;
        clear_stats();
        exp_src = 24'h00A000; exp_dst = 16'h0300;
        pulse_start(24'h00A000, 16'h0300, 10);
        repeat (30) tick();
        pulse_start(24'h0F0000, 16'h7000, 5);
        wait_done("R8 completion");
        chk(wr_cnt == 10 && addr_err == 0 && data_err == 0,
            "R8 first request intact", wr_cnt, 10);
        repeat (60) tick();
        chk(chunk_n - base == 2 && !busy && done_cnt == 1,
            "R8 ignored start never runs", chunk_n - base, 2);
    endtask

    // Watchdog: a hung run ends as a failure with the summary line.
    initial begin
        #3000000;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", total_checks - fail_checks, total_checks + 1);
        $finish;
    end

    initial begin
        clr_req = 1'b1;
        repeat (4) tick();
        rst_n = 1'b1;
        clr_req = 1'b0;
        tick();
        t_reset();
        t_zero_len();
        t_copy(24'h001234, 16'h0100, 3,  0, "short single chunk");
        t_copy(24'h02FFF8, 16'h0800, 20, 0, "remainder chunk");
        t_copy(24'h000040, 16'h1000, 16, 0, "exact multiple");
        t_copy(24'h012300, 16'h2000, 21, 1, "random back-pressure");
        t_copy(24'h000777, 16'h3000, 12, 2, "long stall");
        t_start_busy();
        $display("%0d/%0d checks passed", total_checks - fail_checks, total_checks);
        $finish;
    end
endmodule